// File: doc/BRIEF.md
# Sensor Node Duty-Cycle Sequencer

This block steps a battery-powered sensing node through its repeating work cycle and, at every stage, tells the node's clock-enable controller which low-power mode to run in and which sleep length to use. A cycle starts in a long sleep. A wake pulse from the clock-enable controller moves the node into a brief fully-clocked setup. The node then halts again while the external sensor collects samples. After a second wake it reads the sample, encrypts it and hands it to the radio, and finally returns to the long sleep.

Each working stage is started with a one-cycle start pulse to the unit concerned: the acquisition unit, the cipher or the transmitter. The stage ends on that unit's done pulse. A per-stage timeout returns the node to sleep if a unit never answers. When a new 16-bit reading differs from the previous accepted reading by less than a programmable threshold, nothing is worth sending. In that case the node skips encryption and transmission and lengthens its next sleep by one step. A reading that does change resets the sleep to its shortest long-sleep setting. That shortest setting is nominally 5 minutes, and the longest code is nominally about 21.3 minutes.

Top module: `node_power_seq`

## Requirements
- R1: The state is reported on `stateOut` as 0 = sleep, 1 = setup, 2 = acquire, 3 = encrypt, 4 = transmit. Codes 5 to 7 never appear, and an illegal internal code recovers to sleep. After reset the block is in sleep with `modeOut` = 3 and `sleepCodeOut` = 1.
- R2: In sleep the block waits for `wakeIn`. A wake pulse moves it to setup on the next clock edge, and done pulses arriving in sleep change nothing.
- R3: Setup runs with `modeOut` = 0 (full clock) for exactly STBY_CYC cycles, then moves to acquire.
- R4: Acquire opens with a sensor-sampling halt: `modeOut` = 3, `sleepCodeOut` = 0 and no `acqStart`, held until `wakeIn`. The read phase then runs with `modeOut` = 1 and raises `acqStart` for its first cycle only.
- R5: When `acqDone` brings a reading with high variability, or the first reading after reset, the block enters encrypt. There it runs with `modeOut` = 0 and raises `encStart` for one cycle. `encDone` then leads to transmit, with `modeOut` = 2 and a one-cycle `txStart`, and `txDone` leads back to sleep.
- R6: A reading whose absolute difference from the previous accepted reading is strictly less than `threshIn` is low-variability. For such a reading the block goes from acquire straight to sleep, and the long-sleep code rises by one, saturating at MAX_LONG (7).
- R7: A reading whose difference is equal to or above `threshIn` sets the long-sleep code back to 1.
- R8: If no done pulse arrives within TIMEOUT_CYC cycles of entering the acquire read phase, encrypt or transmit, the block returns to sleep after exactly TIMEOUT_CYC cycles in that stage. The long-sleep code is left unchanged, and a timed-out read records no sample.
- R9: During sleep `sleepCodeOut` lies in 1..MAX_LONG and does not change.
- R10: A done pulse from a unit that is not currently active is ignored; for example, `txDone` or `acqDone` during encrypt does not move the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wakeIn | input | 1 | Sleep-elapsed pulse from the clock-enable controller |
| acqDone | input | 1 | Acquisition unit finished; `sampleIn` valid |
| sampleIn | input | DATA_W | Combined heart-rate / oxygen-saturation reading |
| encDone | input | 1 | Cipher finished |
| txDone | input | 1 | Transmitter finished |
| threshIn | input | DATA_W | Variability threshold |
| stateOut | output | 3 | Current stage code |
| modeOut | output | 2 | Low-power mode request (0 full clock, 1 and 2 divided, 3 halt) |
| sleepCodeOut | output | SCW | Halt length: 0 sensor-sampling wait, 1..MAX_LONG long sleeps |
| acqStart | output | 1 | Start pulse to acquisition unit |
| encStart | output | 1 | Start pulse to cipher |
| txStart | output | 1 | Start pulse to transmitter |

## Verification
The first reading after reset must take the full encrypt-and-transmit path even though the comparison register is empty, which separates "no history" from "no change". A run of small changes, both upward and downward, shows that the magnitude is used rather than a signed difference, and continuing the run past seven steps shows the saturation. A change exactly equal to the threshold separates strict from non-strict comparison. A timed-out read followed by a small change shows that the failed read left neither the code nor the history altered. Stray done pulses during encrypt and a stalled cipher show that only the active unit's pulse or the timer can end a stage.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP   = 3'd0,
    ST_STANDBY = 3'd1,
    ST_ACQ     = 3'd2,
    ST_ENC     = 3'd3,
    ST_TX      = 3'd4
  } nodeState_e;

  // low-power mode requests to the clock-enable controller
  localparam logic [1:0] MODE_ACTIVE = 2'd0;
  localparam logic [1:0] MODE_SLOW   = 2'd1;
  localparam logic [1:0] MODE_SLOWER = 2'd2;
  localparam logic [1:0] MODE_HALT   = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;   // stage or phase changes at this edge
    logic histWrite;  // accept sampleIn into history and adapt sleep code
  } seqStrobe_t;

endpackage

// File: rtl/nps_datapath.sv
module nps_datapath
  import nps_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SCW         = 3,
  parameter int MAX_LONG    = 7,
  parameter int STBY_CYC    = 100,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [DATA_W-1:0] threshIn,
  output logic              stbyHit,
  output logic              timeoutHit,
  output logic              lowVar,
  output logic [SCW-1:0]    longCode
);

  localparam int TMR_TOP_I = (STBY_CYC > TIMEOUT_CYC) ? STBY_CYC : TIMEOUT_CYC;
  localparam int TW        = $clog2(TMR_TOP_I + 1);
  localparam logic [TW-1:0]  TMR_TOP    = TW'(TMR_TOP_I);
  localparam logic [TW-1:0]  STBY_LAST  = TW'(STBY_CYC - 1);
  localparam logic [TW-1:0]  TOUT_LAST  = TW'(TIMEOUT_CYC - 1);
  localparam logic [SCW-1:0] CODE_SHORT = SCW'(1);
  localparam logic [SCW-1:0] CODE_LONG  = SCW'(MAX_LONG);

  logic [TW-1:0]     timerQ;
  logic [DATA_W-1:0] prevQ;
  logic              prevValidQ;
  logic [SCW-1:0]    codeQ;
  logic [DATA_W-1:0] absDiff;

  // stage timer: zero in the first cycle of each stage, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                timerQ <= '0;
    else if (strb.timerClr)   timerQ <= '0;
    else if (timerQ != TMR_TOP) timerQ <= timerQ + 1'b1;
  end

  assign stbyHit    = (timerQ == STBY_LAST);
  assign timeoutHit = (timerQ == TOUT_LAST);

  // magnitude of change against the last accepted reading
  always_comb begin
    if (sampleIn >= prevQ) absDiff = sampleIn - prevQ;
    else                   absDiff = prevQ - sampleIn;
  end

  assign lowVar = prevValidQ && (absDiff < threshIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ      <= '0;
      prevValidQ <= 1'b0;
      codeQ      <= CODE_SHORT;
    end else if (strb.histWrite) begin
      prevQ      <= sampleIn;
      prevValidQ <= 1'b1;
      if (lowVar) codeQ <= (codeQ == CODE_LONG) ? CODE_LONG : codeQ + 1'b1;
      else        codeQ <= CODE_SHORT;
    end
  end

  assign longCode = codeQ;

endmodule

// File: rtl/nps_ctrl.sv
module nps_ctrl
  import nps_pkg::*;
#(
  parameter int SCW = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wakeIn,
  input  logic           acqDone,
  input  logic           encDone,
  input  logic           txDone,
  input  logic           stbyHit,
  input  logic           timeoutHit,
  input  logic           lowVar,
  input  logic [SCW-1:0] longCode,
  output seqStrobe_t     strb,
  output logic [2:0]     stateOut,
  output logic [1:0]     modeOut,
  output logic [SCW-1:0] sleepCodeOut,
  output logic           acqStart,
  output logic           encStart,
  output logic           txStart
);

  nodeState_e stateQ, nextState;
  logic readingQ, nextReading;
  logic entryQ;
  logic moved;

  always_comb begin
    nextState      = stateQ;
    nextReading    = readingQ;
    strb.histWrite = 1'b0;
    case (stateQ)
      ST_SLEEP: begin
        if (wakeIn) nextState = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (stbyHit) begin
          nextState   = ST_ACQ;
          nextReading = 1'b0;
        end
      end
      ST_ACQ: begin
        if (!readingQ) begin
          if (wakeIn) nextReading = 1'b1;
        end else if (acqDone) begin
          strb.histWrite = 1'b1;
          nextReading    = 1'b0;
          nextState      = lowVar ? ST_SLEEP : ST_ENC;
        end else if (timeoutHit) begin
          nextReading = 1'b0;
          nextState   = ST_SLEEP;
        end
      end
      ST_ENC: begin
        if (encDone)         nextState = ST_TX;
        else if (timeoutHit) nextState = ST_SLEEP;
      end
      ST_TX: begin
        if (txDone || timeoutHit) nextState = ST_SLEEP;
      end
      default: begin
        nextState   = ST_SLEEP;
        nextReading = 1'b0;
      end
    endcase
    moved         = (nextState != stateQ) || (nextReading != readingQ);
    strb.timerClr = moved;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_SLEEP;
      readingQ <= 1'b0;
      entryQ   <= 1'b0;
    end else begin
      stateQ   <= nextState;
      readingQ <= nextReading;
      entryQ   <= moved;
    end
  end

  always_comb begin
    modeOut      = MODE_HALT;
    sleepCodeOut = longCode;
    case (stateQ)
      ST_SLEEP:   modeOut = MODE_HALT;
      ST_STANDBY: modeOut = MODE_ACTIVE;
      ST_ACQ: begin
        if (readingQ) modeOut = MODE_SLOW;
        else begin
          modeOut      = MODE_HALT;
          sleepCodeOut = '0;
        end
      end
      ST_ENC:     modeOut = MODE_ACTIVE;
      ST_TX:      modeOut = MODE_SLOWER;
      default:    modeOut = MODE_HALT;
    endcase
  end

  assign stateOut = stateQ;
  assign acqStart = entryQ && (stateQ == ST_ACQ) && readingQ;
  assign encStart = entryQ && (stateQ == ST_ENC);
  assign txStart  = entryQ && (stateQ == ST_TX);

endmodule

// File: rtl/node_power_seq.sv
module node_power_seq
  import nps_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SCW         = 3,
  parameter int MAX_LONG    = 7,
  parameter int STBY_CYC    = 100,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wakeIn,
  input  logic              acqDone,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              encDone,
  input  logic              txDone,
  input  logic [DATA_W-1:0] threshIn,
  output logic [2:0]        stateOut,
  output logic [1:0]        modeOut,
  output logic [SCW-1:0]    sleepCodeOut,
  output logic              acqStart,
  output logic              encStart,
  output logic              txStart
);

  seqStrobe_t     strb;
  logic           stbyHit;
  logic           timeoutHit;
  logic           lowVar;
  logic [SCW-1:0] longCode;

  nps_ctrl #(.SCW(SCW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .acqDone(acqDone),
    .encDone(encDone), .txDone(txDone), .stbyHit(stbyHit),
    .timeoutHit(timeoutHit), .lowVar(lowVar), .longCode(longCode),
    .strb(strb), .stateOut(stateOut), .modeOut(modeOut),
    .sleepCodeOut(sleepCodeOut), .acqStart(acqStart),
    .encStart(encStart), .txStart(txStart)
  );

  nps_datapath #(
    .DATA_W(DATA_W), .SCW(SCW), .MAX_LONG(MAX_LONG),
    .STBY_CYC(STBY_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleIn(sampleIn),
    .threshIn(threshIn), .stbyHit(stbyHit), .timeoutHit(timeoutHit),
    .lowVar(lowVar), .longCode(longCode)
  );

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
  parameter int SCW      = 3,
  parameter int MAX_LONG = 7
) (
  input logic           clk,
  input logic           rstN,
  input logic           wakeIn,
  input logic           encDone,
  input logic           txDone,
  input logic [2:0]     stateOut,
  input logic [1:0]     modeOut,
  input logic [SCW-1:0] sleepCodeOut,
  input logic           acqStart,
  input logic           encStart,
  input logic           txStart
);

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    stateOut <= 3'd4);

  assert_wake_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd0 && wakeIn) |=> stateOut == 3'd1);

  assert_acq_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    acqStart |-> (stateOut == 3'd2 && modeOut == 2'd1));

  assert_enc_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    encStart |-> (stateOut == 3'd3 && $past(stateOut) != 3'd3));

  assert_enc_adv_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd3 && encDone) |=> stateOut == 3'd4);

  assert_tx_adv_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd4 && txDone) |=> (stateOut == 3'd0 && !txStart));

  assert_sleep_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    stateOut == 3'd0 |-> (sleepCodeOut != '0 && sleepCodeOut <= SCW'(MAX_LONG)));

  assert_sleep_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd0 && $past(stateOut) == 3'd0) |-> $stable(sleepCodeOut));

  assert_one_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({acqStart, encStart, txStart}));

endmodule

bind node_power_seq nps_checker #(.SCW(SCW), .MAX_LONG(MAX_LONG)) u_chk (
  .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .encDone(encDone),
  .txDone(txDone), .stateOut(stateOut), .modeOut(modeOut),
  .sleepCodeOut(sleepCodeOut), .acqStart(acqStart),
  .encStart(encStart), .txStart(txStart)
);

// File: tb/sim_node_power_seq.sv
module sim_node_power_seq;

  localparam int DATA_W   = 16;
  localparam int SCW      = 3;
  localparam int MAX_LONG = 7;
  localparam int STBY     = 100;
  localparam int TOUT     = 1024;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wakeIn = 1'b0, acqDone = 1'b0, encDone = 1'b0, txDone = 1'b0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic [DATA_W-1:0] threshIn = 16'd16;
  logic [2:0]        stateOut;
  logic [1:0]        modeOut;
  logic [SCW-1:0]    sleepCodeOut;
  logic              acqStart, encStart, txStart;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of history and sleep code
  bit mPrevValid = 0;
  int mPrev = 0;
  int mCode = 1;

  always #10 clk = ~clk;

  node_power_seq u0 (
    .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .acqDone(acqDone),
    .sampleIn(sampleIn), .encDone(encDone), .txDone(txDone),
    .threshIn(threshIn), .stateOut(stateOut), .modeOut(modeOut),
    .sleepCodeOut(sleepCodeOut), .acqStart(acqStart),
    .encStart(encStart), .txStart(txStart)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseWake();
    @(negedge clk) wakeIn = 1'b1;
    @(negedge clk) wakeIn = 1'b0;
  endtask

  task automatic pulseAcq(input int v);
    @(negedge clk) begin acqDone = 1'b1; sampleIn = DATA_W'(v); end
    @(negedge clk) acqDone = 1'b0;
  endtask

  task automatic pulseEnc();
    @(negedge clk) encDone = 1'b1;
    @(negedge clk) encDone = 1'b0;
  endtask

  task automatic pulseTx();
    @(negedge clk) txDone = 1'b1;
    @(negedge clk) txDone = 1'b0;
  endtask

  // returns whether the model judges v low-variability, and updates the model
  function automatic bit modelAccept(input int v);
    int d = (v >= mPrev) ? v - mPrev : mPrev - v;
    bit low = mPrevValid && (d < int'(threshIn));
    if (low) mCode = (mCode == MAX_LONG) ? MAX_LONG : mCode + 1;
    else     mCode = 1;
    mPrev = v;
    mPrevValid = 1;
    return low;
  endfunction

  // sleep -> setup -> sampling halt -> read phase
  task automatic wakeToRead();
    int n = 0;
    pulseWake();
    chk("R2", "state after wake", int'(stateOut), 1);
    chk("R3", "setup mode", int'(modeOut), 0);
    while (stateOut == 3'd1 && n < 10 * STBY) begin
      n++;
      @(negedge clk);
    end
    chk("R3", "setup length", n, STBY);
    chk("R4", "acquire state", int'(stateOut), 2);
    chk("R4", "sampling halt mode", int'(modeOut), 3);
    chk("R4", "sampling halt code", int'(sleepCodeOut), 0);
    chk("R4", "no acqStart while halted", int'(acqStart), 0);
    pulseWake();
    chk("R4", "read mode", int'(modeOut), 1);
    chk("R4", "acqStart first cycle", int'(acqStart), 1);
    @(negedge clk);
    chk("R4", "acqStart single cycle", int'(acqStart), 0);
  endtask

  task automatic finishHigh();
    chk("R5", "encrypt state", int'(stateOut), 3);
    chk("R5", "encrypt mode", int'(modeOut), 0);
    chk("R5", "encStart", int'(encStart), 1);
    pulseEnc();
    chk("R5", "transmit state", int'(stateOut), 4);
    chk("R5", "transmit mode", int'(modeOut), 2);
    chk("R5", "txStart", int'(txStart), 1);
    pulseTx();
    chk("R5", "sleep after tx", int'(stateOut), 0);
    chk("R5", "sleep mode", int'(modeOut), 3);
  endtask

  task automatic runCycle(input int v, input string req);
    bit low;
    wakeToRead();
    pulseAcq(v);
    low = modelAccept(v);
    if (low) begin
      chk("R6", "skip to sleep", int'(stateOut), 0);
    end else begin
      finishHigh();
    end
    chk(req, "long sleep code", int'(sleepCodeOut), mCode);
  endtask

  task automatic testReset();
    chk("R1", "reset state", int'(stateOut), 0);
    chk("R1", "reset mode", int'(modeOut), 3);
    chk("R1", "reset sleep code", int'(sleepCodeOut), 1);
    chk("R1", "reset starts", int'({acqStart, encStart, txStart}), 0);
  endtask

  task automatic testIgnoreInSleep();
    @(negedge clk) begin acqDone = 1'b1; encDone = 1'b1; txDone = 1'b1; sampleIn = 16'd77; end
    @(negedge clk) begin acqDone = 1'b0; encDone = 1'b0; txDone = 1'b0; end
    chk("R2", "done pulses ignored in sleep", int'(stateOut), 0);
    chk("R2", "code untouched in sleep", int'(sleepCodeOut), 1);
  endtask

  task automatic testSaturation();
    runCycle(1005, "R6");   // +5 -> 2
    runCycle(995, "R6");    // -10 -> 3
    runCycle(1000, "R6");   // 4
    runCycle(1000, "R6");   // 5
    runCycle(1000, "R6");   // 6
    runCycle(1000, "R6");   // 7
    runCycle(1000, "R6");   // stays 7
    chk("R6", "saturated code", int'(sleepCodeOut), MAX_LONG);
  endtask

  task automatic testSleepStable();
    int c0 = int'(sleepCodeOut);
    repeat (5) @(negedge clk);
    chk("R9", "sleep code stable", int'(sleepCodeOut), c0);
    chk("R9", "still asleep", int'(stateOut), 0);
  endtask

  task automatic testStrayDone();
    wakeToRead();
    pulseAcq(2000);
    void'(modelAccept(2000));
    chk("R10", "in encrypt", int'(stateOut), 3);
    @(negedge clk) begin txDone = 1'b1; acqDone = 1'b1; end
    @(negedge clk) begin txDone = 1'b0; acqDone = 1'b0; end
    chk("R10", "stray done ignored", int'(stateOut), 3);
    pulseEnc();
    chk("R10", "encDone still works", int'(stateOut), 4);
    pulseTx();
    chk("R10", "back to sleep", int'(stateOut), 0);
  endtask

  task automatic testAcqTimeout();
    int n = 0;
    int c0;
    runCycle(2005, "R6");     // code 2, history 2005
    c0 = int'(sleepCodeOut);
    wakeToRead();             // already one read cycle elapsed
    n = 1;
    while (stateOut == 3'd2 && n < 4 * TOUT) begin
      n++;
      @(negedge clk);
    end
    chk("R8", "read timeout length", n, TOUT);
    chk("R8", "sleep after read timeout", int'(stateOut), 0);
    chk("R8", "code kept after timeout", int'(sleepCodeOut), c0);
    runCycle(2010, "R8");     // low against 2005 -> 3
  endtask

  task automatic testEncTimeout();
    int n = 0;
    wakeToRead();
    pulseAcq(9000);
    void'(modelAccept(9000));
    while (stateOut == 3'd3 && n < 4 * TOUT) begin
      n++;
      @(negedge clk);
    end
    chk("R8", "encrypt timeout length", n, TOUT);
    chk("R8", "sleep after encrypt timeout", int'(stateOut), 0);
    chk("R8", "code after encrypt timeout", int'(sleepCodeOut), mCode);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIgnoreInSleep();
    runCycle(1000, "R5");     // first reading: full path
    testSaturation();
    testSleepStable();
    runCycle(1016, "R7");     // difference equal to threshold -> code 1
    testStrayDone();
    testAcqTimeout();
    testEncTimeout();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule